// File: doc/BRIEF.md
# Display Identification Block Reader

This block fetches a display's identification data over a simple byte-wide request/response bus and keeps it in a 256-byte buffer. It has two address spaces. The sink register space holds the display's capability and test registers. The device space reaches the identification memory at 7-bit device address 0x50. A `start_i` pulse starts a fixed sequence. The block first reads the 12-byte sink capability area, retrying after a programmable gap if that read fails. It then reads the extension-count byte. It reads the 128-byte base block and, when the count is nonzero, the second 128-byte block. Each block is checked so that its bytes sum to zero modulo 256.

A checksum mismatch or a bus error aborts the current attempt. The whole identification read is then attempted again, up to a bounded total. After a good read, the block checks the sink's test-request register. If that register asks for it, the block writes back the final checksum byte and a response flag. The outcome comes out as a one-cycle `done_o` with a two-bit result code. The buffer can be read at any time through a combinational index port.

Top module: `edid_reader`

## Requirements
- R1: After reset the block is idle. `bus_req_o`, `done_o` and `busy_o` are low and `err_o` is 0.
- R2: After `start_i`, the block first makes single-byte reads in sink space (`bus_sel_o`=1) at CAP_BASE to CAP_BASE+CAP_LEN-1. A bus error on any of these reads restarts the capability read after exactly CAP_GAP_CYC idle cycles with `bus_req_o` low, up to CAP_RETRIES restarts. If every run fails, `done_o` comes with `err_o`=2 and no device-space access is made.
- R3: Identification reads use device space (`bus_sel_o`=0, `bus_dev_o`=0x50, `bus_we_o`=0). Each attempt begins by reading offset 126, the extension count.
- R4: An extension count of 0 gives one block read of offsets 0..127. Any nonzero count gives reads of offsets 0..255 in order, and `two_blk_o`=1 at completion.
- R5: Each byte read at offset k is stored at buffer index k and shows on `rd_byte_o` when `rd_idx_i`=k.
- R6: Each 128-byte block is accepted only if the 8-bit wrapping sum of its bytes is zero. The two blocks are checked independently, and a rejected block yields result code 1 (checksum).
- R7: A bus error during any identification read ends the attempt with result code 2 (bus).
- R8: At most EDID_TRIES attempts (default 3) are made, and each one restarts at the extension-count read. A passing attempt gives `err_o`=0. If all attempts fail, `err_o` is the code of the last failure. The code is never 3.
- R9: After the blocks pass, the block reads sink register 0x218. If bit 2 of that register is set, it writes the byte at offset 127 of the last block read to sink register 0x261, then writes 0x04 to 0x260. Otherwise no write is made. An error in these steps leaves `err_o`=0.
- R10: `done_o` is a one-cycle pulse. `err_o` and `two_blk_o` stay valid from that pulse until the next completion. A `start_i` that arrives while `busy_o` is high is ignored.
- R11: While `bus_req_o` is high and `bus_rsp_i` is low, `bus_addr_o`, `bus_sel_o`, `bus_we_o` and `bus_wdata_o` are held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 0 ok, 1 checksum, 2 bus |
| two_blk_o | output | 1 | Two blocks were read in the passing attempt |
| bus_req_o | output | 1 | Bus request, held until response |
| bus_sel_o | output | 1 | 1 = sink register space, 0 = device space |
| bus_dev_o | output | 7 | Device address (0x50 in device space, 0 otherwise) |
| bus_we_o | output | 1 | Write request |
| bus_addr_o | output | ADDR_W | Register address or byte offset |
| bus_wdata_o | output | 8 | Write data |
| bus_rsp_i | input | 1 | One-cycle response strobe |
| bus_rdata_i | input | 8 | Read data, valid with the strobe |
| bus_err_i | input | 1 | Bus error, valid with the strobe |
| rd_idx_i | input | 8 | Buffer read index |
| rd_byte_o | output | 8 | Buffer byte at rd_idx_i |

## Verification
The bench tries the main function with several kinds of display image. These are a clean single-block image, a clean two-block image, and a nonzero extension count other than one. Comparing them shows whether the extension count selects the read length. It also shows whether the stored bytes match what was read. Corrupted bytes are then injected into the base block or the extension block on chosen attempts only. This tells apart independent per-block checking, correct retry counting, and reporting of the last failure's code against the first. Bus errors are injected in the capability phase, in the identification phase and in the test-request phase. These show that each phase has its own recovery policy.

// File: rtl/edid_pkg.sv
`timescale 1ns/1ps
package edid_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_CKSUM = 2'd1,
    RES_BUS   = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CAP, S_GAP, S_EXT, S_BLK, S_TREQ, S_TCKS, S_TRSP
  } seq_st_e;

  localparam logic [6:0] EDID_DEV_ADDR = 7'h50;
  localparam logic [7:0] EXT_CNT_OFS   = 8'd126;
  localparam int         BLK_BYTES     = 128;
endpackage

// File: rtl/edid_cksum.sv
`timescale 1ns/1ps
module edid_cksum (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] sum_nx_o
);
  logic [7:0] sum_q;

  assign sum_nx_o = sum_q + byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_nx_o;
  end

  assert_clr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_q == 8'd0));
endmodule

// File: rtl/edid_buf.sv
`timescale 1ns/1ps
module edid_buf #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/edid_seq.sv
`timescale 1ns/1ps
module edid_seq
  import edid_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CAP_BASE    = 0,
  parameter int CAP_LEN     = 12,
  parameter int CAP_RETRIES = 5,
  parameter int CAP_GAP_CYC = 1250000,
  parameter int EDID_TRIES  = 3,
  parameter int TREQ_ADDR   = 'h218,
  parameter int TCKS_ADDR   = 'h261,
  parameter int TRSP_ADDR   = 'h260,
  parameter int TREQ_BIT    = 2,
  parameter int TRSP_BIT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic              two_blk_o,
  output logic              bus_req_o,
  output logic              bus_sel_o,
  output logic [6:0]        bus_dev_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_rsp_i,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_err_i,
  output logic              buf_we_o,
  output logic [7:0]        buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [7:0]        cks_raddr_o,
  input  logic [7:0]        cks_byte_i,
  output logic              ck_clr_o,
  output logic              ck_add_o,
  input  logic [7:0]        ck_sum_nx_i
);
  localparam int CT_W = $clog2(CAP_RETRIES + 1);
  localparam int AT_W = $clog2(EDID_TRIES + 1);
  localparam int GW   = $clog2(CAP_GAP_CYC + 1);
  localparam logic [6:0]      CAP_LAST = 7'(CAP_LEN - 1);
  localparam logic [CT_W-1:0] CT_MAX   = CT_W'(CAP_RETRIES);
  localparam logic [AT_W-1:0] AT_LAST  = AT_W'(EDID_TRIES - 1);
  localparam logic [GW-1:0]   GAP_LAST = GW'(CAP_GAP_CYC - 1);
  localparam logic [7:0]      RSP_VAL  = 8'(1 << TRSP_BIT);

  seq_st_e         state_q;
  logic [6:0]      idx_q;
  logic            blk_q, ext_q;
  logic [CT_W-1:0] cap_try_q;
  logic [AT_W-1:0] att_q;
  logic [GW-1:0]   gap_q;

  logic blk_end, fail, att_fail, ok_fin, cap_dead, report;
  res_e fail_code, rpt_code;

  // bus drive
  always_comb begin
    bus_req_o   = state_q inside {S_CAP, S_EXT, S_BLK, S_TREQ, S_TCKS, S_TRSP};
    bus_sel_o   = state_q inside {S_CAP, S_TREQ, S_TCKS, S_TRSP};
    bus_we_o    = state_q inside {S_TCKS, S_TRSP};
    bus_dev_o   = bus_sel_o ? 7'd0 : EDID_DEV_ADDR;
    bus_wdata_o = (state_q == S_TCKS) ? cks_byte_i :
                  (state_q == S_TRSP) ? RSP_VAL : 8'd0;
    case (state_q)
      S_CAP:   bus_addr_o = ADDR_W'(CAP_BASE) + ADDR_W'(idx_q);
      S_EXT:   bus_addr_o = ADDR_W'(EXT_CNT_OFS);
      S_BLK:   bus_addr_o = ADDR_W'({blk_q, idx_q});
      S_TREQ:  bus_addr_o = ADDR_W'(TREQ_ADDR);
      S_TCKS:  bus_addr_o = ADDR_W'(TCKS_ADDR);
      S_TRSP:  bus_addr_o = ADDR_W'(TRSP_ADDR);
      default: bus_addr_o = '0;
    endcase
  end

  // buffer and running sum run alongside the byte stream
  assign buf_we_o    = (state_q == S_BLK) && bus_rsp_i && !bus_err_i;
  assign buf_waddr_o = {blk_q, idx_q};
  assign buf_wdata_o = bus_rdata_i;
  assign cks_raddr_o = {blk_q, 7'h7F};
  assign blk_end     = (state_q == S_BLK) && (idx_q == 7'h7F);
  assign ck_add_o    = buf_we_o;
  assign ck_clr_o    = bus_rsp_i && ((state_q == S_EXT) || blk_end);

  always_comb begin
    fail      = bus_rsp_i && (((state_q == S_EXT) && bus_err_i) ||
                ((state_q == S_BLK) && (bus_err_i || (blk_end && ck_sum_nx_i != 8'd0))));
    fail_code = bus_err_i ? RES_BUS : RES_CKSUM;
    att_fail  = fail && (att_q != AT_LAST);
    ok_fin    = bus_rsp_i && (((state_q == S_TREQ) && (bus_err_i || !bus_rdata_i[TREQ_BIT])) ||
                (state_q == S_TRSP));
    cap_dead  = bus_rsp_i && bus_err_i && (state_q == S_CAP) && (cap_try_q == CT_MAX);
    report    = ok_fin || cap_dead || (fail && !att_fail);
    rpt_code  = cap_dead ? RES_BUS : (fail ? fail_code : RES_OK);
  end

  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      blk_q     <= 1'b0;
      ext_q     <= 1'b0;
      cap_try_q <= '0;
      att_q     <= '0;
      gap_q     <= '0;
      done_o    <= 1'b0;
      err_o     <= RES_OK;
      two_blk_o <= 1'b0;
    end else begin
      done_o <= report;
      if (report) begin
        err_o     <= rpt_code;
        two_blk_o <= ok_fin && ext_q;
        state_q   <= S_IDLE;
      end else if (att_fail) begin
        att_q   <= att_q + 1'b1;
        idx_q   <= '0;
        blk_q   <= 1'b0;
        state_q <= S_EXT;
      end else begin
        case (state_q)
          S_IDLE: if (start_i) begin
            state_q   <= S_CAP;
            idx_q     <= '0;
            cap_try_q <= '0;
            att_q     <= '0;
          end
          S_CAP: if (bus_rsp_i) begin
            if (bus_err_i) begin
              cap_try_q <= cap_try_q + 1'b1;
              gap_q     <= '0;
              state_q   <= S_GAP;
            end else if (idx_q == CAP_LAST) begin
              state_q <= S_EXT;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          S_GAP: begin
            if (gap_q == GAP_LAST) begin
              state_q <= S_CAP;
              idx_q   <= '0;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
          S_EXT: if (bus_rsp_i) begin
            ext_q   <= |bus_rdata_i;
            idx_q   <= '0;
            blk_q   <= 1'b0;
            state_q <= S_BLK;
          end
          S_BLK: if (bus_rsp_i) begin
            if (idx_q == 7'h7F) begin
              if (!blk_q && ext_q) begin
                blk_q <= 1'b1;
                idx_q <= '0;
              end else begin
                state_q <= S_TREQ;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          S_TREQ: if (bus_rsp_i) state_q <= S_TCKS;
          S_TCKS: if (bus_rsp_i) state_q <= S_TRSP;
          default: ;
        endcase
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_rsp_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_sel_o)
                                   && $stable(bus_we_o) && $stable(bus_wdata_o)));
  assert_code_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o != 2'd3));
  assert_att_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q < AT_W'(EDID_TRIES));
  assert_dev_read_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_sel_o) |-> (!bus_we_o && bus_dev_o == 7'h50));
  assert_cap_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (bus_req_o && bus_sel_o && !bus_we_o));
endmodule

// File: rtl/edid_reader.sv
`timescale 1ns/1ps
module edid_reader
  import edid_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CAP_BASE    = 0,
  parameter int CAP_LEN     = 12,
  parameter int CAP_RETRIES = 5,
  parameter int CAP_GAP_CYC = 1250000,
  parameter int EDID_TRIES  = 3,
  parameter int TREQ_ADDR   = 'h218,
  parameter int TCKS_ADDR   = 'h261,
  parameter int TRSP_ADDR   = 'h260,
  parameter int TREQ_BIT    = 2,
  parameter int TRSP_BIT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic              two_blk_o,
  output logic              bus_req_o,
  output logic              bus_sel_o,
  output logic [6:0]        bus_dev_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_rsp_i,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_err_i,
  input  logic [7:0]        rd_idx_i,
  output logic [7:0]        rd_byte_o
);
  localparam int DEPTH = 2 * BLK_BYTES;

  logic       buf_we, ck_clr, ck_add;
  logic [7:0] buf_waddr, buf_wdata, cks_raddr, cks_byte, ck_sum_nx;

  edid_seq #(
    .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .CAP_LEN(CAP_LEN),
    .CAP_RETRIES(CAP_RETRIES), .CAP_GAP_CYC(CAP_GAP_CYC), .EDID_TRIES(EDID_TRIES),
    .TREQ_ADDR(TREQ_ADDR), .TCKS_ADDR(TCKS_ADDR), .TRSP_ADDR(TRSP_ADDR),
    .TREQ_BIT(TREQ_BIT), .TRSP_BIT(TRSP_BIT)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .err_o, .two_blk_o,
    .bus_req_o, .bus_sel_o, .bus_dev_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_rsp_i, .bus_rdata_i, .bus_err_i,
    .buf_we_o(buf_we), .buf_waddr_o(buf_waddr), .buf_wdata_o(buf_wdata),
    .cks_raddr_o(cks_raddr), .cks_byte_i(cks_byte),
    .ck_clr_o(ck_clr), .ck_add_o(ck_add), .ck_sum_nx_i(ck_sum_nx)
  );

  edid_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i,
    .we_i(buf_we), .waddr_i(buf_waddr), .wdata_i(buf_wdata),
    .raddr_a_i(rd_idx_i), .rdata_a_o(rd_byte_o),
    .raddr_b_i(cks_raddr), .rdata_b_o(cks_byte)
  );

  edid_cksum u_cksum (
    .clk_i, .rst_ni,
    .clr_i(ck_clr), .add_i(ck_add), .byte_i(buf_wdata), .sum_nx_o(ck_sum_nx)
  );
endmodule

// File: tb/edid_reader_bench.sv
`timescale 1ns/1ps
module edid_reader_bench;
  localparam int GAP = 20;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, two_blk_o, bus_req_o, bus_sel_o, bus_we_o;
  logic [1:0]  err_o;
  logic [6:0]  bus_dev_o;
  logic [11:0] bus_addr_o;
  logic [7:0]  bus_wdata_o, rd_byte_o;
  logic        rsp = 1'b0, berr = 1'b0;
  logic [7:0]  rdata = 8'd0, rd_idx = 8'd0;

  edid_reader #(.CAP_GAP_CYC(GAP)) u_edid_reader (
    .clk_i(clk), .rst_ni, .start_i, .busy_o, .done_o, .err_o, .two_blk_o,
    .bus_req_o, .bus_sel_o, .bus_dev_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_rsp_i(rsp), .bus_rdata_i(rdata), .bus_err_i(berr),
    .rd_idx_i(rd_idx), .rd_byte_o
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_done = 0;
  bit finished = 1'b0;

  typedef struct { int err; int two; } exp_t;
  exp_t exp_q[$];

  // sink / device model
  logic [7:0] mem [256];
  logic [7:0] treq_val;
  bit         treq_err;
  int         cap_fail_runs, cap_failed;
  logic [7:0] m_cks0, m_cks1, m_bus;
  int n_cap_rd, n_edid_rd, n_wr, n_att, max_ofs, gap_seen, prev_ofs, n_bad_dev;
  int wr_addr [4];
  int wr_data [4];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    treq_val = 8'h00; treq_err = 1'b0;
    cap_fail_runs = 0; cap_failed = 0;
    m_cks0 = '0; m_cks1 = '0; m_bus = '0;
    n_cap_rd = 0; n_edid_rd = 0; n_wr = 0; n_att = 0; max_ofs = -1;
    gap_seen = -1; prev_ofs = 0; n_bad_dev = 0;
    for (int i = 0; i < 4; i++) begin wr_addr[i] = -1; wr_data[i] = -1; end
  endtask

  task automatic fill_mem(logic [7:0] ext, logic [7:0] seed);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < 127; i++) begin
      mem[i] = (i == 126) ? ext : 8'(i * 13 + int'(seed));
      s = s + mem[i];
    end
    mem[127] = 8'(0 - s);
    s = 8'd0;
    for (int i = 128; i < 255; i++) begin
      mem[i] = 8'(i * 7 + int'(seed));
      s = s + mem[i];
    end
    mem[255] = 8'(0 - s);
  endtask

  // responder: answers each held request after two low cycles
  initial begin
    int wcnt, ofs, a, low;
    bit gap_pend;
    wcnt = 0; low = 0; gap_pend = 1'b0;
    forever begin
      @(negedge clk);
      if (gap_pend) begin
        if (!bus_req_o) low++;
        else begin gap_seen = low; gap_pend = 1'b0; end
      end
      if (rsp) begin
        rsp = 1'b0; berr = 1'b0; wcnt = 0;
      end else if (bus_req_o) begin
        if (wcnt < 1) wcnt++;
        else begin
          rsp = 1'b1; berr = 1'b0; rdata = 8'd0;
          if (bus_sel_o) begin
            if (bus_we_o) begin
              if (n_wr < 4) begin
                wr_addr[n_wr] = int'(bus_addr_o);
                wr_data[n_wr] = int'(bus_wdata_o);
              end
              n_wr++;
            end else if (bus_addr_o == 12'h218) begin
              rdata = treq_val; berr = treq_err;
            end else begin
              n_cap_rd++;
              rdata = bus_addr_o[7:0] ^ 8'h5A;
              if (bus_addr_o == 12'h000 && cap_failed < cap_fail_runs) begin
                berr = 1'b1; cap_failed++; gap_pend = 1'b1; low = 0;
              end
            end
          end else begin
            n_edid_rd++;
            if (bus_dev_o != 7'h50 || bus_we_o) n_bad_dev++;
            ofs = int'(bus_addr_o[7:0]);
            if (ofs == 126 && prev_ofs != 125) n_att++;
            a = (n_att > 0) ? ((n_att - 1) & 7) : 0;
            rdata = mem[ofs];
            if (ofs > max_ofs) max_ofs = ofs;
            if (m_bus[a] && ofs == 40) berr = 1'b1;
            if (m_cks0[a] && ofs == 5) rdata = rdata ^ 8'h01;
            if (m_cks1[a] && ofs == 200) rdata = rdata ^ 8'h01;
            prev_ofs = ofs;
          end
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    bit prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done_o) begin
        n_done++;
        if (prev) check("R10 done longer than one cycle", 1, 0);
        if (exp_q.size() == 0) check("R10 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check("R8 result code", int'(err_o), e.err);
          check("R4 two_blk_o", int'(two_blk_o), e.two);
        end
      end
      prev = done_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_case(int e_err, int e_two);
    exp_t e;
    int d0;
    e.err = e_err; e.two = e_two;
    exp_q.push_back(e);
    d0 = n_done;
    pulse_start();
    while (n_done == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_buf(string tag, int idx);
    rd_idx = 8'(idx);
    @(negedge clk);
    check(tag, int'(rd_byte_o), int'(mem[idx]));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int d0;
    clear_stats();
    fill_mem(8'd0, 8'd1);
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 bus_req_o", int'(bus_req_o), 0);
    check("R1 done_o", int'(done_o), 0);
    check("R1 busy_o", int'(busy_o), 0);
    check("R1 err_o", int'(err_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // single block, no test request
    clear_stats(); fill_mem(8'd0, 8'd3);
    run_case(0, 0);
    check("R2 capability reads", n_cap_rd, 12);
    check("R3 device space reads well formed", n_bad_dev, 0);
    check("R4 reads for one block", n_edid_rd, 129);
    check("R4 highest offset", max_ofs, 127);
    check("R9 no write without request", n_wr, 0);
    chk_buf("R5 buffer byte 0", 0);
    chk_buf("R5 buffer byte 77", 77);
    chk_buf("R5 buffer byte 127", 127);

    // two blocks, test request set
    clear_stats(); fill_mem(8'd1, 8'd9); treq_val = 8'h04;
    run_case(0, 1);
    check("R4 reads for two blocks", n_edid_rd, 257);
    check("R9 write count", n_wr, 2);
    check("R9 checksum write addr", wr_addr[0], 'h261);
    check("R9 checksum write data", wr_data[0], int'(mem[255]));
    check("R9 response write addr", wr_addr[1], 'h260);
    check("R9 response write data", wr_data[1], 4);
    chk_buf("R5 buffer byte 200", 200);
    chk_buf("R5 buffer byte 255", 255);
    repeat (50) @(negedge clk);
    check("R10 err_o held", int'(err_o), 0);
    check("R10 two_blk_o held", int'(two_blk_o), 1);

    // extension block bad on every attempt
    clear_stats(); fill_mem(8'd1, 8'd5); m_cks1 = 8'h07;
    run_case(1, 0);
    check("R6 attempts on extension checksum", n_att, 3);
    check("R8 reads over three attempts", n_edid_rd, 3 * 257);
    repeat (10) @(negedge clk);
    check("R10 err_o held after failure", int'(err_o), 1);

    // base block bad on first attempt only
    clear_stats(); fill_mem(8'd0, 8'd7); m_cks0 = 8'h01;
    run_case(0, 0);
    check("R6 attempts after one bad base block", n_att, 2);
    chk_buf("R5 buffer byte 5 rewritten", 5);

    // bus error on every attempt
    clear_stats(); fill_mem(8'd0, 8'd2); m_bus = 8'h07;
    run_case(2, 0);
    check("R7 attempts on bus error", n_att, 3);
    check("R7 reads stop at error", n_edid_rd, 3 * 42);

    // checksum, checksum, then bus error: last code wins
    clear_stats(); fill_mem(8'd0, 8'd4); m_cks0 = 8'h03; m_bus = 8'h04;
    run_case(2, 0);
    check("R8 attempts mixed failures", n_att, 3);

    // two checksum failures then success on the final attempt
    clear_stats(); fill_mem(8'd0, 8'd6); m_cks0 = 8'h03;
    run_case(0, 0);
    check("R8 success on last attempt", n_att, 3);

    // capability read recovers after the full retry budget
    clear_stats(); fill_mem(8'd0, 8'd8); cap_fail_runs = 5;
    run_case(0, 0);
    check("R2 capability reads with five retries", n_cap_rd, 17);
    check("R2 gap length", gap_seen, GAP);

    // capability read never succeeds
    clear_stats(); fill_mem(8'd0, 8'd8); cap_fail_runs = 6;
    run_case(2, 0);
    check("R2 capability runs before giving up", n_cap_rd, 6);
    check("R2 no device access after capability failure", n_edid_rd, 0);

    // test request without the read bit
    clear_stats(); fill_mem(8'd3, 8'd11); treq_val = 8'hFB;
    run_case(0, 1);
    check("R9 other request bits ignored", n_wr, 0);

    // test request register read fails
    clear_stats(); fill_mem(8'd0, 8'd12); treq_val = 8'h04; treq_err = 1'b1;
    run_case(0, 0);
    check("R9 request read error no write", n_wr, 0);

    // nonzero count other than one selects two blocks
    clear_stats(); fill_mem(8'd5, 8'd13);
    run_case(0, 1);
    check("R4 count five reads two blocks", n_edid_rd, 257);

    // start while busy is ignored
    clear_stats(); fill_mem(8'd0, 8'd14);
    begin
      exp_t e;
      e.err = 0; e.two = 0;
      exp_q.push_back(e);
      d0 = n_done;
      pulse_start();
      repeat (30) @(negedge clk);
      pulse_start();
      while (n_done == d0) @(negedge clk);
      repeat (300) @(negedge clk);
      check("R10 one done for two starts", n_done - d0, 1);
      check("R10 capability not restarted", n_cap_rd, 12);
      check("R10 busy low after done", int'(busy_o), 0);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule